// File: doc/BRIEF.md
# Double-Buffer Transmit Handoff Controller

This block sits on the device side of a host-to-device transmit path that has two fixed packet buffers. The host tracks a free-running input count and the device tracks a free-running output count. The host is allowed to copy a frame while fewer than two frames are outstanding, that is, while the modulo difference of the two counts is below the buffer count. The host then rings a doorbell, and the device advances the input count and raises an interrupt towards the internal consuming engine. When the consumer has finished reading a buffer, it signals that the buffer is free, and the output count advances.

The buffer for the next host write is the low bit of the input count. The buffer for the next consumer read is the low bit of the output count, so both sides alternate buffers on every frame. The output count can be read as status at any time without side effects. Each buffer is sized by the surrounding memory to hold a maximum-size Ethernet frame plus its header and descriptor; payload storage itself lies outside this block.

A doorbell that arrives while both buffers are occupied is dropped and sets a sticky overflow error. A buffer-free signal that arrives while nothing is outstanding is dropped.

Top module: `txh_ctrl`

## Requirements
- R1: After reset:
  - both counts read 0 and both buffer selects read 0;
  - `host_may_wr_o` is 1;
  - `occ_full_o`, `cons_pend_o`, `cons_irq_o` and `ovf_err_o` are 0;
  - `fill_o` is 0.
- R2: A doorbell accepted while the difference is below 2 raises `host_in_cnt_o` by one on the next clock. `host_buf_sel_o` always equals bit 0 of the input count.
- R3: A doorbell while the difference is 2 leaves `host_in_cnt_o` unchanged and sets `ovf_err_o`. `ovf_err_o` then stays 1 until reset.
- R4: `cons_irq_o` is high for exactly the one cycle after each accepted doorbell and is never raised by a rejected one.
- R5: A `cons_free_i` pulse while the difference is nonzero raises `stat_out_cnt_o` by one on the next clock. `cons_buf_sel_o` always equals bit 0 of the output count.
- R6: A `cons_free_i` pulse while the difference is 0 leaves `stat_out_cnt_o` unchanged.
- R7: With d = (input count − output count) mod 256:
  - `fill_o` equals d;
  - `host_may_wr_o` is 1 exactly when d < 2;
  - `occ_full_o` is 1 exactly when d = 2;
  - `cons_pend_o` is 1 exactly when d > 0;
  - d never exceeds 2.
- R8: Both 8-bit counts wrap from 255 to 0, and the occupancy flags stay correct across the wrap.
- R9: Doorbell and buffer-free in the same cycle:
  - each is judged against the difference before that cycle;
  - at difference 1, both counts advance;
  - at difference 2, only the output count advances and the overflow error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_bell_i | input | 1 | Host doorbell: one frame written |
| cons_free_i | input | 1 | Consumer finished reading its current buffer |
| host_in_cnt_o | output | 8 | Input count |
| stat_out_cnt_o | output | 8 | Output count status, side-effect free |
| host_buf_sel_o | output | 1 | Buffer the host fills next |
| cons_buf_sel_o | output | 1 | Buffer the consumer reads next |
| host_may_wr_o | output | 1 | Host may copy a frame now |
| occ_full_o | output | 1 | Both buffers occupied |
| cons_pend_o | output | 1 | At least one frame awaits the consumer |
| fill_o | output | 2 | Frames outstanding |
| cons_irq_o | output | 1 | Interrupt pulse to the consumer |
| ovf_err_o | output | 1 | Sticky doorbell overflow error |

## Verification
The bench runs more than 256 frames through the block to cross the counter wrap. A design that compares the raw counts instead of their modulo difference would stall the host forever once the input count wraps below the output count.

The bench rings a doorbell with both buffers full. It expects the input count to be frozen, the error to latch and no interrupt; a design without this guard would let the difference reach 3 and point the host at a buffer still being read.

The bench pulses buffer-free with nothing outstanding, which a careless design would turn into a negative occupancy. It also fires both strobes together at differences 1 and 2, where judging one strobe against the already-updated difference would accept or reject the wrong one.

// File: rtl/txh_pkg.sv
package txh_pkg;
  localparam int TXH_CNT_W = 8;
  localparam int TXH_NBUF  = 2;

  typedef struct packed {
    logic may_wr;
    logic full;
    logic pend;
  } txh_occ_t;
endpackage

// File: rtl/txh_rst_sync.sv
module txh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/txh_cnt.sv
module txh_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (inc_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // counter only ever steps by one
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + W'(1))); // R2
endmodule

// File: rtl/txh_occ.sv
module txh_occ #(
  parameter int W    = 8,
  parameter int NBUF = 2,
  localparam int FILL_W = $clog2(NBUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      in_cnt,
  input  logic [W-1:0]      out_cnt,
  output txh_pkg::txh_occ_t occ,
  output logic [FILL_W-1:0] fill
);
  logic [W-1:0] diff;

  always_comb begin
    diff       = in_cnt - out_cnt;
    occ.may_wr = (diff < W'(NBUF));
    occ.full   = (diff == W'(NBUF));
    occ.pend   = (diff != '0);
    fill       = diff[FILL_W-1:0];
  end

  AST_DIFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt - out_cnt) <= W'(NBUF)); // R7
endmodule

// File: rtl/txh_ctrl.sv
module txh_ctrl #(
  parameter int CNT_W = txh_pkg::TXH_CNT_W,
  parameter int NBUF  = txh_pkg::TXH_NBUF,
  localparam int SEL_W  = $clog2(NBUF),
  localparam int FILL_W = $clog2(NBUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_bell_i,
  input  logic              cons_free_i,
  output logic [CNT_W-1:0]  host_in_cnt_o,
  output logic [CNT_W-1:0]  stat_out_cnt_o,
  output logic [SEL_W-1:0]  host_buf_sel_o,
  output logic [SEL_W-1:0]  cons_buf_sel_o,
  output logic              host_may_wr_o,
  output logic              occ_full_o,
  output logic              cons_pend_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              cons_irq_o,
  output logic              ovf_err_o
);
  logic              rst_ni;
  logic              acc_wr, acc_rd;
  logic              irq_q, irq_d, err_q, err_d;
  logic [CNT_W-1:0]  in_cnt, out_cnt;
  txh_pkg::txh_occ_t occ;

  txh_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  txh_cnt #(.W(CNT_W)) u_in_cnt (
    .clk(clk), .rst_n(rst_ni), .inc_en(acc_wr), .cnt(in_cnt));

  txh_cnt #(.W(CNT_W)) u_out_cnt (
    .clk(clk), .rst_n(rst_ni), .inc_en(acc_rd), .cnt(out_cnt));

  txh_occ #(.W(CNT_W), .NBUF(NBUF)) u_occ (
    .clk(clk), .rst_n(rst_ni), .in_cnt(in_cnt), .out_cnt(out_cnt),
    .occ(occ), .fill(fill_o));

  // both strobes judged against the occupancy before this cycle
  always_comb begin
    acc_wr = host_bell_i & occ.may_wr;
    acc_rd = cons_free_i & occ.pend;
    irq_d  = acc_wr;
    err_d  = err_q | (host_bell_i & ~occ.may_wr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  assign host_in_cnt_o  = in_cnt;
  assign stat_out_cnt_o = out_cnt;
  assign host_buf_sel_o = in_cnt[SEL_W-1:0];
  assign cons_buf_sel_o = out_cnt[SEL_W-1:0];
  assign host_may_wr_o  = occ.may_wr;
  assign occ_full_o     = occ.full;
  assign cons_pend_o    = occ.pend;
  assign cons_irq_o     = irq_q;
  assign ovf_err_o      = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (occ_full_o && host_bell_i) |=> $stable(host_in_cnt_o)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o); // R3
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    cons_irq_o |-> $past(host_bell_i)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cons_pend_o && cons_free_i) |=> $stable(stat_out_cnt_o)); // R6
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ni)
    !(occ_full_o && host_may_wr_o)); // R7
endmodule

// File: tb/txh_ctrl_test.sv
`timescale 1ns/1ps
module txh_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bell = 1'b0, free = 1'b0;
  logic [7:0] in_cnt, out_cnt;
  logic hsel, csel, may_wr, full, pend, irq, err;
  logic [1:0] fill;
  int n_run = 0, n_fail = 0;
  int e_in = 0, e_out = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txh_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_bell_i(bell), .cons_free_i(free),
    .host_in_cnt_o(in_cnt), .stat_out_cnt_o(out_cnt),
    .host_buf_sel_o(hsel), .cons_buf_sel_o(csel),
    .host_may_wr_o(may_wr), .occ_full_o(full), .cons_pend_o(pend),
    .fill_o(fill), .cons_irq_o(irq), .ovf_err_o(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare the whole state with the bench model
  task automatic chk_state(input string req);
    int d;
    d = (e_in - e_out) & 255;
    chk(in_cnt == 8'(e_in), {req, " in_cnt"}, in_cnt, e_in & 255);
    chk(out_cnt == 8'(e_out), {req, " out_cnt"}, out_cnt, e_out & 255);
    chk(hsel == e_in[0], {req, " R2 host sel"}, hsel, e_in[0]);
    chk(csel == e_out[0], {req, " R5 cons sel"}, csel, e_out[0]);
    chk(fill == 2'(d), {req, " R7 fill"}, fill, d);
    chk(may_wr == (d < 2), {req, " R7 may_wr"}, may_wr, d < 2);
    chk(full == (d == 2), {req, " R7 full"}, full, d == 2);
    chk(pend == (d != 0), {req, " R7 pend"}, pend, d != 0);
  endtask

  task automatic step(input logic b, input logic f);
    bell = b; free = f;
    @(negedge clk);
    bell = 1'b0; free = 1'b0;
  endtask

  task automatic t_reset;
    chk_state("R1");
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(err == 1'b0, "R1 err", err, 0);
  endtask

  task automatic t_fill;
    step(1, 0); e_in++;
    chk(irq == 1'b1, "R4 irq after bell", irq, 1);
    chk_state("R2 one");
    step(0, 0);
    chk(irq == 1'b0, "R4 irq one cycle", irq, 0);
    step(1, 0); e_in++;
    chk(irq == 1'b1, "R4 irq second", irq, 1);
    chk_state("R2 two");
  endtask

  task automatic t_overflow;
    step(1, 0);
    chk(irq == 1'b0, "R3 R4 no irq on reject", irq, 0);
    chk(err == 1'b1, "R3 err set", err, 1);
    chk_state("R3 unchanged");
    step(0, 0);
    chk(err == 1'b1, "R3 err sticky", err, 1);
  endtask

  task automatic t_drain;
    step(0, 1); e_out++;
    chk_state("R5 one");
    step(0, 1); e_out++;
    chk_state("R5 two");
  endtask

  task automatic t_underflow;
    step(0, 1);
    chk_state("R6 ignored");
    step(0, 1);
    chk_state("R6 ignored again");
  endtask

  task automatic t_simul;
    step(1, 0); e_in++;
    step(1, 1); e_in++; e_out++;
    chk(irq == 1'b1, "R9 d1 irq", irq, 1);
    chk_state("R9 d1 both");
    step(1, 0); e_in++;
    step(1, 1); e_out++;
    chk(irq == 1'b0, "R9 d2 no irq", irq, 0);
    chk_state("R9 d2 only free");
    step(0, 1); e_out++;
    chk_state("R9 drained");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 300; i++) begin
      step(1, 0); e_in++;
      if (i % 2 == 1) begin
        step(0, 1); e_out++;
        step(0, 1); e_out++;
      end
      if (i == 255 || i == 257) chk_state("R8 near wrap");
    end
    chk_state("R8 after wrap");
    step(1, 0); e_in++;
    chk_state("R8 wrapped d1");
    step(1, 0); e_in++;
    chk_state("R8 wrapped full");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill();
    t_overflow();
    t_drain();
    t_underflow();
    t_simul();
    t_wrap();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule